// File: doc/BRIEF.md
# Condition Register File with Arithmetic Flag Extension

This block holds the processor's condition state: a 32-bit condition register split into eight 4-bit fields, plus a five-bit extension that carries the arithmetic summary flags (carry, 32-bit carry, overflow, 32-bit overflow and sticky summary overflow). The writeback stage drives its single write port. That port has a per-field mask for the condition register and a separate enable for the flag extension, so either part can be updated without disturbing the other.

The decode stage reads both values every cycle, unconditionally, through one combinational read port. There is no write-to-read bypass: a write shows up on the read port in the cycle after the clock edge that commits it. The write enables act as the valid qualifiers of the write stream. The block never applies back-pressure, so every write presented with an enable high is taken on the next rising edge. For that reason the block has no ready output.

Top module: `cond_flag_file`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, the condition register reads as all zeros and all five flags read as zero.
- R2: When `wb_cr_en` is high, each field i whose mask bit `wb_cr_mask[i]` is set takes `wb_cr_data[4i+3:4i]` at the rising edge. Each field whose mask bit is clear keeps its value.
- R3: When `wb_cr_en` is low, the condition register does not change, whatever the mask and data are.
- R4: When `wb_flag_en` is high, all five flags take `wb_flags` at the rising edge. The bit order is: bit 0 carry, bit 1 32-bit carry, bit 2 overflow, bit 3 32-bit overflow, bit 4 summary overflow.
- R5: When `wb_flag_en` is low, the flags do not change.
- R6: A condition-register write leaves the flags unchanged, and a flag write leaves the condition register unchanged.
- R7: A condition-register write and a flag write in the same cycle are both committed on the same edge.
- R8: The read outputs show the stored state only. During the cycle a write is presented, they still show the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cr_en | input | 1 | Condition-register write qualifier |
| wb_cr_mask | input | 8 | Per-field write mask, bit i selects field i |
| wb_cr_data | input | 32 | Condition-register write data |
| wb_flag_en | input | 1 | Flag-extension write qualifier |
| wb_flags | input | 5 | Flag write data |
| rd_cr | output | 32 | Stored condition register |
| rd_flags | output | 5 | Stored flags |

## Verification
A masked condition-register write and a flag write can fall in the same cycle. The random phase drives both enables independently on every cycle, so the two collide often, and directed steps force the collision with all-ones and all-zeros patterns. Each result is judged against a bench model that updates both parts on the same edge. The bench also checks both read outputs in the cycle the write is presented, to confirm that no new value leaks through early.

// File: rtl/cff_pkg.sv
package cff_pkg;
  localparam int unsigned CFF_FIELD_W   = 4;
  localparam int unsigned CFF_FIELD_CNT = 8;
  localparam int unsigned CFF_CR_W      = CFF_FIELD_W * CFF_FIELD_CNT;
  localparam int unsigned CFF_FLAG_CNT  = 5;

  // flag bit positions inside the extension word
  localparam int unsigned FLG_CARRY   = 0;
  localparam int unsigned FLG_CARRY32 = 1;
  localparam int unsigned FLG_OVF     = 2;
  localparam int unsigned FLG_OVF32   = 3;
  localparam int unsigned FLG_SUMOVF  = 4;
endpackage

// File: rtl/cff_field_bank.sv
module cff_field_bank #(
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned FIELD_CNT = 8,
  localparam int unsigned CR_W     = FIELD_W * FIELD_CNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [FIELD_CNT-1:0] wr_mask,
  input  logic [CR_W-1:0]      wr_data,
  output logic [CR_W-1:0]      cr_q
);
  // one register slice per field, loaded only when its mask bit is set
  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
    logic [FIELD_W-1:0] field_q;
    logic               field_ld;

    assign field_ld = wr_en & wr_mask[f];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        field_q <= '0;
      end else if (field_ld) begin
        field_q <= wr_data[f*FIELD_W +: FIELD_W];
      end
    end

    assign cr_q[f*FIELD_W +: FIELD_W] = field_q;
  end
endmodule

// File: rtl/cff_flag_reg.sv
module cff_flag_reg #(
  parameter int unsigned FLAG_CNT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [FLAG_CNT-1:0] wr_data,
  output logic [FLAG_CNT-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= wr_data;
    end
  end
endmodule

// File: rtl/cond_flag_file.sv
module cond_flag_file
  import cff_pkg::*;
#(
  parameter int unsigned FIELD_W   = CFF_FIELD_W,
  parameter int unsigned FIELD_CNT = CFF_FIELD_CNT,
  parameter int unsigned FLAG_CNT  = CFF_FLAG_CNT,
  localparam int unsigned CR_W     = FIELD_W * FIELD_CNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wb_cr_en,
  input  logic [FIELD_CNT-1:0] wb_cr_mask,
  input  logic [CR_W-1:0]      wb_cr_data,
  input  logic                 wb_flag_en,
  input  logic [FLAG_CNT-1:0]  wb_flags,
  output logic [CR_W-1:0]      rd_cr,
  output logic [FLAG_CNT-1:0]  rd_flags
);
  logic [CR_W-1:0]     cr_store;
  logic [FLAG_CNT-1:0] flag_store;

  cff_field_bank #(
    .FIELD_W  (FIELD_W),
    .FIELD_CNT(FIELD_CNT)
  ) u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wb_cr_en),
    .wr_mask(wb_cr_mask),
    .wr_data(wb_cr_data),
    .cr_q   (cr_store)
  );

  cff_flag_reg #(
    .FLAG_CNT(FLAG_CNT)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wb_flag_en),
    .wr_data(wb_flags),
    .flags_q(flag_store)
  );

  // read port: stored state only, no bypass from the write port
  assign rd_cr    = cr_store;
  assign rd_flags = flag_store;
endmodule

// File: rtl/cond_flag_file_chk.sv
module cond_flag_file_chk #(
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned FIELD_CNT = 8,
  parameter int unsigned FLAG_CNT  = 5,
  localparam int unsigned CR_W     = FIELD_W * FIELD_CNT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wb_cr_en,
  input logic [FIELD_CNT-1:0] wb_cr_mask,
  input logic [CR_W-1:0]      wb_cr_data,
  input logic                 wb_flag_en,
  input logic [FLAG_CNT-1:0]  wb_flags,
  input logic [CR_W-1:0]      rd_cr,
  input logic [FLAG_CNT-1:0]  rd_flags
);
  logic [CR_W-1:0] bit_mask;
  for (genvar f = 0; f < FIELD_CNT; f++) begin : g_bm
    assign bit_mask[f*FIELD_W +: FIELD_W] = {FIELD_W{wb_cr_mask[f]}};
  end

  AST_CR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cr_en |=> rd_cr == (($past(rd_cr) & ~$past(bit_mask)) | ($past(wb_cr_data) & $past(bit_mask)))); // R2
  AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_cr_en |=> $stable(rd_cr)); // R3
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_flag_en |=> rd_flags == $past(wb_flags)); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_flag_en |=> $stable(rd_flags)); // R5
  AST_BOTH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cr_en && wb_flag_en && (wb_cr_mask != '0)) |=>
      (rd_flags == $past(wb_flags)) &&
      ((rd_cr & $past(bit_mask)) == ($past(wb_cr_data) & $past(bit_mask)))); // R7
endmodule

bind cond_flag_file cond_flag_file_chk #(
  .FIELD_W  (FIELD_W),
  .FIELD_CNT(FIELD_CNT),
  .FLAG_CNT (FLAG_CNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wb_cr_en  (wb_cr_en),
  .wb_cr_mask(wb_cr_mask),
  .wb_cr_data(wb_cr_data),
  .wb_flag_en(wb_flag_en),
  .wb_flags  (wb_flags),
  .rd_cr     (rd_cr),
  .rd_flags  (rd_flags)
);

// File: tb/cond_flag_file_test.sv
`timescale 1ns/1ps
module cond_flag_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_cr_en = 1'b0;
  logic [7:0]  wb_cr_mask = '0;
  logic [31:0] wb_cr_data = '0;
  logic        wb_flag_en = 1'b0;
  logic [4:0]  wb_flags = '0;
  logic [31:0] rd_cr;
  logic [4:0]  rd_flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_cr = '0;
  logic [4:0]  m_fl = '0;
  string       last_tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  cond_flag_file uut (
    .clk(clk), .rst_n(rst_n),
    .wb_cr_en(wb_cr_en), .wb_cr_mask(wb_cr_mask), .wb_cr_data(wb_cr_data),
    .wb_flag_en(wb_flag_en), .wb_flags(wb_flags),
    .rd_cr(rd_cr), .rd_flags(rd_flags)
  );

  function automatic logic [31:0] widen(input logic [7:0] m);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (m[i]) r[4*i +: 4] = 4'hF;
    return r;
  endfunction

  function automatic logic [31:0] merged(input logic [31:0] old, input logic [7:0] m,
                                         input logic [31:0] d);
    return (old & ~widen(m)) | (d & widen(m));
  endfunction

  task automatic chk_cr(input string tag, input logic [31:0] exp);
    total++;
    if (rd_cr !== exp) begin
      bad++;
      $display("FAIL %s cr actual=%h expected=%h", tag, rd_cr, exp);
    end
  endtask

  task automatic chk_fl(input string tag, input logic [4:0] exp);
    total++;
    if (rd_flags !== exp) begin
      bad++;
      $display("FAIL %s flags actual=%b expected=%b", tag, rd_flags, exp);
    end
  endtask

  // called at a negedge: checks result of previous step, drives new one,
  // checks no early visibility, lets the edge commit and updates the model
  task automatic step(input string tag, input logic ce, input logic [7:0] m,
                      input logic [31:0] d, input logic fe, input logic [4:0] f);
    chk_cr(last_tag, m_cr);
    chk_fl(last_tag, m_fl);
    wb_cr_en = ce; wb_cr_mask = m; wb_cr_data = d;
    wb_flag_en = fe; wb_flags = f;
    #1;
    chk_cr("R8", m_cr);
    chk_fl("R8", m_fl);
    @(posedge clk);
    if (ce) m_cr = merged(m_cr, m, d);
    if (fe) m_fl = f;
    last_tag = tag;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk_cr("R1", 32'h0);   // in reset
    chk_fl("R1", 5'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cr("R1", 32'h0);
    chk_fl("R1", 5'h0);

    // directed
    step("R2", 1, 8'hFF, 32'hDEADBEEF, 0, 5'h00);
    step("R2", 1, 8'h01, 32'h12345678, 0, 5'h00);
    step("R2", 1, 8'h80, 32'hA0000000, 0, 5'h00);
    step("R2", 1, 8'h00, 32'hFFFFFFFF, 0, 5'h00);
    step("R3", 0, 8'hFF, 32'h00000000, 0, 5'h1F);
    step("R4", 0, 8'hFF, 32'h0, 1, 5'b10101);   // sumovf, ovf, carry
    step("R5", 0, 8'h00, 32'h0, 0, 5'b01010);
    step("R6", 1, 8'h5A, 32'h5A5A5A5A, 0, 5'h00);
    step("R6", 0, 8'h00, 32'hFFFFFFFF, 1, 5'b00001);
    step("R7", 1, 8'hFF, 32'hFFFFFFFF, 1, 5'h1F);
    step("R7", 1, 8'hFF, 32'h00000000, 1, 5'h00);
    step("R7", 1, 8'h3C, 32'hCAFEF00D, 1, 5'b10010);

    // constrained random
    for (int n = 0; n < 2000; n++) begin
      logic ce, fe;
      logic [7:0] m;
      ce = ($urandom % 3) != 0;
      fe = ($urandom % 2) != 0;
      m  = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
      step(ce && fe ? "R7" : (ce ? "R2" : (fe ? "R4" : "R3")),
           ce, m, $urandom, fe, 5'($urandom));
    end
    step("R5", 0, 8'h00, 32'h0, 0, 5'h00);
    chk_cr(last_tag, m_cr);
    chk_fl(last_tag, m_fl);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule